// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt events from a few external pins, a group of internal peripheral event pulses and a small set of non-maskable trap inputs. It presents a single vector request to a CPU model at a time. Every maskable source has a sticky flag, an enable bit and a 3-bit priority. External pins are resynchronised and edge-detected, and each pin has its own polarity selection. Traps are always enabled and rank above every maskable source.

The controller tracks the running CPU priority level, which is 0 for foreground code. A source is requested only when its level is strictly higher than the running level, so a higher-priority handler can preempt a lower one. When the CPU acknowledges a request, the running level is pushed onto an internal stack and then raised to the level of the request that was taken. A return strobe pops the stack and restores the previous level. A simple register port gives software write and read access to the flags, the enables, the polarities and the priorities.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable, priority, flag and polarity is 0, the running level is 0 and `irq_req` is 0. An `irq_ack` while `irq_req` is 0 has no effect on the level.
- R2: A source event sets that source's flag even when the source's enable bit is 0. A maskable source is a candidate only when its flag is 1, its enable is 1 and its priority is non-zero.
- R3: A source whose priority field is 0 never raises a request, even when its flag and enable are both 1.
- R4: A request is raised only when the winning candidate's level is strictly greater than the running level. A candidate at a level equal to the running level does not preempt.
- R5: The candidate with the highest level wins. Among candidates at the same level, the lowest vector number wins. Trap t has vector t. Maskable source s has vector N_TRAP+s. Sources 0..N_EXT-1 are the external pins and the peripheral events follow them.
- R6: Each external pin passes through a two-flop synchronizer. Its polarity bit selects the active edge: 1 for falling, 0 for rising. An active edge on the pin sets the pin's flag on the third clock edge after the pin changes. The inactive edge sets nothing.
- R7: Taking an interrupt never clears a flag, so a flag that is still set re-requests once the level drops. Software clears a flag by writing a 0 to it. A hardware set in the same cycle as that write wins.
- R8: Trap inputs set sticky trap flags and need no enable. Trap t has level 8+N_TRAP-1-t, which is above every maskable priority, so trap 0 ranks highest.
- R9: An `irq_ack` while `irq_req` is 1 pushes the running level onto the stack and sets the running level to the taken request's level. `irq_req` is low in the following cycle unless a strictly higher candidate exists. The stack never overflows.
- R10: An `irq_ret` pops the stack and restores the saved level. An `irq_ret` with an empty stack, at level 0, is ignored. When `irq_ack` is also taken in the same cycle, the acknowledge wins and the return is ignored.
- R11: The register map is as follows. Address 0 holds the enables, bit s for source s. Address 1 holds the flags, bit s. Address 2 holds the trap flags, bit t. Address 3 holds the pin polarities, bit p. Address 16+s holds source s's priority in bits [2:0]. Reads are combinational, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| per_evt | input | N_PER | Peripheral event pulses, one cycle each |
| trap_in | input | N_TRAP | Trap event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_ack | input | 1 | CPU acknowledges the current request |
| irq_ret | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | A vector request is pending |
| irq_vec | output | VEC_W | Vector number of the pending request |
| cpu_level | output | LVL_W | Running CPU priority level |

## Verification
The checker watches every cycle for the following. The level must rise strictly on a taken acknowledge, and the same vector must not be re-requested right after it is taken. The level must stay unchanged without an acknowledge or a return, and must fall strictly on a return. The stack must be empty exactly when the level is 0, and it must never exceed its depth. Some behaviours can only be shown by the bench scenarios. These are which vector wins (tie-breaking and trap ranking), the three-edge pin latency and the polarity selection, flags latching while disabled, the set-over-clear race, and re-firing after return when a flag is left set.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 3;
    localparam int TRAP_BASE_LVL = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE = 5'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 5'd1;
    localparam logic [ADDR_W-1:0] A_TRAPS  = 5'd2;
    localparam logic [ADDR_W-1:0] A_POLAR  = 5'd3;
    localparam int                A_PRIO0  = 16;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pe_t;

    pe_t q, d;

    always_comb begin
        d    = q;
        d.s1 = pin;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt = fall_sel ? (!q.s2 && q.s3) : (q.s2 && !q.s3);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N     = 9,
    parameter int LVL_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0][LVL_W-1:0] cand_lvl,
    output logic [LVL_W-1:0]        best_lvl,
    output logic [IDX_W-1:0]        best_idx
);
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_lvl[i] != '0 && cand_lvl[i] >= best_lvl) begin
                best_lvl = cand_lvl[i];
                best_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int W     = 4,
    parameter int DEPTH = 9,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     top,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } stk_t;

    stk_t q, d;
    logic [CNT_W-1:0] top_idx;

    assign top_idx = q.cnt - 1'b1;

    always_comb begin
        d = q;
        if (push && q.cnt < CNT_W'(DEPTH)) begin
            d.mem[q.cnt] = din;
            d.cnt        = q.cnt + 1'b1;
        end else if (pop && q.cnt != '0) begin
            d.cnt = top_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign top = (q.cnt != '0) ? q.mem[top_idx] : '0;
    assign cnt = q.cnt;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_EXT  = 3,
    parameter int N_PER  = 4,
    parameter int N_TRAP = 2,
    localparam int N_SRC = N_EXT + N_PER,
    localparam int N_VEC = N_TRAP + N_SRC,
    localparam int LVL_W = $clog2(irq_pkg::TRAP_BASE_LVL + N_TRAP),
    localparam int VEC_W = $clog2(N_VEC),
    localparam int DEPTH = irq_pkg::TRAP_BASE_LVL - 1 + N_TRAP,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_EXT-1:0]          ext_pin,
    input  logic [N_PER-1:0]          per_evt,
    input  logic [N_TRAP-1:0]         trap_in,
    input  logic                      reg_we,
    input  logic [irq_pkg::ADDR_W-1:0] reg_addr,
    input  logic [irq_pkg::DATA_W-1:0] reg_wdata,
    output logic [irq_pkg::DATA_W-1:0] reg_rdata,
    input  logic                      irq_ack,
    input  logic                      irq_ret,
    output logic                      irq_req,
    output logic [VEC_W-1:0]          irq_vec,
    output logic [LVL_W-1:0]          cpu_level
);
    import irq_pkg::*;

    typedef struct packed {
        logic [N_SRC-1:0]             flag;
        logic [N_SRC-1:0]             en;
        logic [N_EXT-1:0]             pol;
        logic [N_TRAP-1:0]            tflag;
        logic [N_SRC-1:0][PRIO_W-1:0] prio;
        logic [LVL_W-1:0]             level;
        logic                         req;
        logic [VEC_W-1:0]             vec;
        logic [LVL_W-1:0]             wlvl;
    } st_t;

    st_t q, nxt, d;

    logic [N_EXT-1:0]            ext_evt;
    logic [N_SRC-1:0]            src_evt;
    logic [N_VEC-1:0][LVL_W-1:0] cand;
    logic [LVL_W-1:0]            best_lvl;
    logic [VEC_W-1:0]            best_idx;
    logic [LVL_W-1:0]            stk_top;
    logic [CNT_W-1:0]            stk_cnt;
    logic                        take;
    logic                        pop;

    for (genvar p = 0; p < N_EXT; p++) begin : g_pin
        irq_pin_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_pin[p]),
            .fall_sel (q.pol[p]),
            .evt      (ext_evt[p])
        );
    end

    assign src_evt = {per_evt, ext_evt};
    assign take    = irq_ack && q.req;
    assign pop     = irq_ret && !take && (stk_cnt != '0);

    // next values of everything except the arbitration result
    always_comb begin
        nxt = q;
        if (reg_we && reg_addr == A_ENABLE) nxt.en    = reg_wdata[N_SRC-1:0];
        if (reg_we && reg_addr == A_FLAGS)  nxt.flag  = reg_wdata[N_SRC-1:0];
        if (reg_we && reg_addr == A_TRAPS)  nxt.tflag = reg_wdata[N_TRAP-1:0];
        if (reg_we && reg_addr == A_POLAR)  nxt.pol   = reg_wdata[N_EXT-1:0];
        for (int k = 0; k < N_SRC; k++) begin
            if (reg_we && reg_addr == ADDR_W'(A_PRIO0 + k))
                nxt.prio[k] = reg_wdata[PRIO_W-1:0];
        end
        nxt.flag  = nxt.flag | src_evt;
        nxt.tflag = nxt.tflag | trap_in;
        if (take)     nxt.level = q.wlvl;
        else if (pop) nxt.level = stk_top;
    end

    always_comb begin
        for (int t = 0; t < N_TRAP; t++)
            cand[t] = nxt.tflag[t] ? LVL_W'(TRAP_BASE_LVL + N_TRAP - 1 - t) : '0;
        for (int s = 0; s < N_SRC; s++)
            cand[N_TRAP+s] = (nxt.flag[s] && nxt.en[s]) ? LVL_W'(nxt.prio[s]) : '0;
    end

    irq_arbiter #(.N(N_VEC), .LVL_W(LVL_W)) u_arb (
        .cand_lvl (cand),
        .best_lvl (best_lvl),
        .best_idx (best_idx)
    );

    always_comb begin
        d      = nxt;
        d.req  = best_lvl > nxt.level;
        d.vec  = best_idx;
        d.wlvl = best_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    irq_level_stack #(.W(LVL_W), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (pop),
        .din   (q.level),
        .top   (stk_top),
        .cnt   (stk_cnt)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_ENABLE: reg_rdata[N_SRC-1:0]  = q.en;
            A_FLAGS:  reg_rdata[N_SRC-1:0]  = q.flag;
            A_TRAPS:  reg_rdata[N_TRAP-1:0] = q.tflag;
            A_POLAR:  reg_rdata[N_EXT-1:0]  = q.pol;
            default: begin
                for (int k = 0; k < N_SRC; k++) begin
                    if (reg_addr == ADDR_W'(A_PRIO0 + k))
                        reg_rdata[PRIO_W-1:0] = q.prio[k];
                end
            end
        endcase
    end

    assign irq_req   = q.req;
    assign irq_vec   = q.vec;
    assign cpu_level = q.level;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int LVL_W = 4,
    parameter int VEC_W = 4,
    parameter int CNT_W = 4,
    parameter int DEPTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             irq_ack,
    input logic             irq_ret,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [LVL_W-1:0] cpu_level,
    input logic [CNT_W-1:0] stk_cnt
);
    a_r9_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> cpu_level > $past(cpu_level));

    a_r9_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !reg_we) |=> (!irq_req || irq_vec != $past(irq_vec)));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= CNT_W'(DEPTH));

    a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(irq_ack && irq_req) && !irq_ret) |=> $stable(cpu_level));

    a_r10_ret_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !(irq_ack && irq_req) && cpu_level != '0) |=> cpu_level < $past(cpu_level));

    a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_level == '0) == (stk_cnt == '0));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .cpu_level (cpu_level),
    .stk_cnt   (stk_cnt)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int N_EXT = 3, N_PER = 4, N_TRAP = 2;
    localparam int VEC_W = 4, LVL_W = 4;

    logic              clk = 0, rst_n = 0;
    logic [N_EXT-1:0]  ext_pin = '0;
    logic [N_PER-1:0]  per_evt = '0;
    logic [N_TRAP-1:0] trap_in = '0;
    logic              reg_we = 0;
    logic [4:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0, reg_rdata;
    logic              irq_ack = 0, irq_ret = 0, irq_req;
    logic [VEC_W-1:0]  irq_vec;
    logic [LVL_W-1:0]  cpu_level;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        logic  req;
        int    vec;
        int    lvl;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl #(.N_EXT(N_EXT), .N_PER(N_PER), .N_TRAP(N_TRAP)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .per_evt(per_evt),
        .trap_in(trap_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .cpu_level(cpu_level)
    );

    // monitor: compares outputs against expected items as they arrive
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            n_chk++;
            if (irq_req !== e.req || int'(cpu_level) != e.lvl ||
                (e.req && int'(irq_vec) != e.vec)) begin
                n_fail++;
                $display("FAIL %s: req=%0b vec=%0d lvl=%0d expected req=%0b vec=%0d lvl=%0d",
                         e.tag, irq_req, irq_vec, cpu_level, e.req, e.vec, e.lvl);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic req, int vec, int lvl);
        exp_t e;
        e.tag = tag; e.req = req; e.vec = vec; e.lvl = lvl;
        exp_q.push_back(e);
        #0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] v);
        reg_we = 1; reg_addr = a; reg_wdata = v;
        tick();
        reg_we = 0;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] v);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== v) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata, v);
        end
    endtask

    task automatic pulse_per(logic [N_PER-1:0] m);
        per_evt = m; tick(); per_evt = '0;
    endtask

    task automatic pulse_trap(logic [N_TRAP-1:0] m);
        trap_in = m; tick(); trap_in = '0;
    endtask

    task automatic ack();
        irq_ack = 1; tick(); irq_ack = 0;
    endtask

    task automatic ret();
        irq_ret = 1; tick(); irq_ret = 0;
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        expect_out("R1 reset", 0, 0, 0);
        rd_chk("R1 enables zero", 5'd0, 32'h0);
        rd_chk("R1 prio zero", 5'd16, 32'h0);
        ack();
        expect_out("R1 ack without req", 0, 0, 0);

        // R2 flag latches while disabled; R11 map
        pulse_per(4'b0001);
        expect_out("R2 disabled no req", 0, 0, 0);
        rd_chk("R2 flag latched", 5'd1, 32'h08);
        wr(5'd0, 32'h08);
        rd_chk("R11 enable readback", 5'd0, 32'h08);
        expect_out("R3 prio zero masks", 0, 0, 0);
        wr(5'd19, 32'd2);
        rd_chk("R11 prio readback", 5'd19, 32'd2);
        expect_out("R2 enabled request", 1, 5, 0);

        // R9 acknowledge
        ack();
        expect_out("R9 ack raises level", 0, 0, 2);
        rd_chk("R7 flag kept after ack", 5'd1, 32'h08);

        // R4 nesting
        wr(5'd0, 32'h18);
        wr(5'd20, 32'd2);
        pulse_per(4'b0010);
        expect_out("R4 equal level no preempt", 0, 0, 2);
        wr(5'd20, 32'd5);
        expect_out("R4 higher preempts", 1, 6, 2);
        ack();
        expect_out("R9 nested level", 0, 0, 5);
        ret();
        expect_out("R7 refire after ret", 1, 6, 2);
        wr(5'd1, 32'h08);
        expect_out("R7 sw clear", 0, 0, 2);
        ret();
        expect_out("R10 restore level 0", 1, 5, 0);
        wr(5'd1, 32'h00);
        expect_out("R7 clear all", 0, 0, 0);
        ret();
        expect_out("R10 ret at empty ignored", 0, 0, 0);

        // R5 tie break and priority order
        wr(5'd0, 32'h60);
        wr(5'd21, 32'd4);
        wr(5'd22, 32'd4);
        pulse_per(4'b1100);
        expect_out("R5 tie lowest vector", 1, 7, 0);
        wr(5'd22, 32'd5);
        expect_out("R5 higher level wins", 1, 8, 0);
        wr(5'd1, 32'h00);
        expect_out("R5 cleared", 0, 0, 0);

        // R6 edge detection, rising then falling
        wr(5'd0, 32'h02);
        wr(5'd17, 32'd3);
        ext_pin[1] = 1;
        tick(); tick();
        expect_out("R6 not yet after two edges", 0, 0, 0);
        tick();
        expect_out("R6 rising sets flag", 1, 3, 0);
        wr(5'd1, 32'h00);
        ext_pin[1] = 0;
        repeat (4) tick();
        expect_out("R6 falling ignored when rising", 0, 0, 0);
        wr(5'd3, 32'h02);
        rd_chk("R11 polarity readback", 5'd3, 32'h02);
        ext_pin[1] = 1;
        repeat (4) tick();
        expect_out("R6 rising ignored when falling", 0, 0, 0);
        ext_pin[1] = 0;
        tick(); tick(); tick();
        expect_out("R6 falling sets flag", 1, 3, 0);
        wr(5'd1, 32'h00);
        wr(5'd0, 32'h00);

        // R7 set beats simultaneous clear
        reg_we = 1; reg_addr = 5'd1; reg_wdata = 32'h0; per_evt = 4'b0001;
        tick();
        reg_we = 0; per_evt = '0;
        rd_chk("R7 set wins over clear", 5'd1, 32'h08);

        // R8 traps
        wr(5'd0, 32'h08);
        wr(5'd19, 32'd7);
        expect_out("R8 setup prio7", 1, 5, 0);
        pulse_trap(2'b10);
        expect_out("R8 trap over prio7", 1, 1, 0);
        ack();
        expect_out("R8 trap level 8", 0, 0, 8);
        pulse_trap(2'b01);
        expect_out("R8 trap0 preempts trap1", 1, 0, 8);
        ack();
        expect_out("R9 trap0 level 9", 0, 0, 9);
        ret();
        expect_out("R10 back to 8 trap0 refires", 1, 0, 8);
        rd_chk("R8 trap flags sticky", 5'd2, 32'h3);
        wr(5'd2, 32'h0);
        expect_out("R8 traps cleared", 0, 0, 8);
        ret();
        expect_out("R10 back to 0", 1, 5, 0);

        wait (exp_q.size() == 0);
        #1;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule